// File: doc/BRIEF.md
# Sync-Bit Clock Correction Counter

This block measures the bit rate of one of three Manchester decoders against a slow reference. Each decoder raises a one-cycle strobe whenever it sees a sync bit. A write to a 2-bit select field picks a decoder and starts a measurement. The block then counts that decoder's sync strobes across a window of 512 ticks of a 32 kHz reference. When the window closes, the count goes into a 16-bit result register. Software compares that count with the expected number of bits and trims its clock to match.

The result register reads zero from the start of a measurement until the window closes. Writing the all-ones select code cancels any running measurement and starts no new one. Starting a new measurement while one is running restarts both the window and the count.

All inputs are single-cycle strobes that are already synchronous to `clk`. The block has no data stream, so it has no valid/ready handshake and no back-pressure. The select write is accepted in the cycle it is presented, and the result is a plain level output.

Top module: `sync_clock_meter`

## Requirements
- R1: After reset, `result` is 0000h and no measurement is running.
- R2: A write (`sel_wr`=1) with `sel_data` of 0, 1 or 2 starts a measurement of decoder `sync_evt[sel_data]`. The write cycle is cycle 0 of the measurement.
- R3: From the cycle after a start write until the window closes, `result` reads 0000h.
- R4: The window closes on the 512th cycle with `ref_tick`=1 after the start write. In the next cycle `result` holds the count, and it then stays unchanged until the next select write.
- R5: Strobes on the two decoders that are not selected are never counted.
- R6: A start write during a measurement restarts both the tick window and the count from zero, on the newly written decoder.
- R7: The count saturates at FFFFh and never wraps.
- R8: A write of 3 (11b) aborts any measurement and clears `result` to 0000h. Later ticks and strobes leave `result` at 0000h.
- R9: A strobe in the same cycle as the closing tick is included in the result.
- R10: A strobe in the cycle of the start write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Select-field write strobe |
| sel_data | input | 2 | Select code written: 0..2 = decoder, 3 = disable |
| sync_evt | input | 3 | Per-decoder sync-bit strobes |
| ref_tick | input | 1 | One-cycle strobe per 32 kHz reference period |
| result | output | 16 | Correction count; 0000h while measuring |

## Verification
A stuck busy flag is visible at once: `result` stays at zero, or it never takes its final value one cycle after the 512th tick. A window counter that is off by one moves the load of `result` by a whole tick period. A wrong select latch or a lost clear only shows when the window closes, as a result value that does not match. For this reason the bench runs a behavioural model next to the design and compares `result` every cycle. It also runs dedicated scenarios that close the window with strobes on the boundary cycles.

// File: rtl/scm_pkg.sv
package scm_pkg;
  localparam int SEL_W = 2;
  typedef logic [SEL_W-1:0] dec_sel_t;
  // all-ones code requests disable
  localparam dec_sel_t SEL_OFF = '1;
endpackage

// File: rtl/scm_window_timer.sv
module scm_window_timer #(
  parameter int WIN_LOG2 = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic tick,
  output logic busy,
  output logic last_tick
);
  logic [WIN_LOG2-1:0] tick_cnt;

  // closing tick: the last count value, not overridden by a write
  assign last_tick = busy && tick && (tick_cnt == '1) && !start && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tick_cnt <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      tick_cnt <= '0;
    end else if (abort) begin
      busy     <= 1'b0;
      tick_cnt <= '0;
    end else if (busy && tick) begin
      tick_cnt <= tick_cnt + 1'b1;
      if (tick_cnt == '1) busy <= 1'b0;
    end
  end

  a_r4_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> !busy);

  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/scm_event_counter.sv
module scm_event_counter #(
  parameter int CNT_W   = 16,
  parameter int NUM_DEC = 3,
  parameter int SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic [SEL_W-1:0] sel,
  input  logic [NUM_DEC-1:0] evt,
  output logic [CNT_W-1:0] count_next
);
  localparam int SEL_LIM = 1 << SEL_W;

  logic [CNT_W-1:0]   count;
  logic [SEL_LIM-1:0] evt_pad;
  logic               hit;

  assign evt_pad = SEL_LIM'(evt);
  assign hit     = enable && evt_pad[sel];

  // saturating increment
  assign count_next = (hit && count != '1) ? count + 1'b1 : count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (enable) count <= count_next;
  end

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && count == '1) |=> count == '1);

  a_r5_no_stray_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !hit) |=> $stable(count));

endmodule

// File: rtl/sync_clock_meter.sv
module sync_clock_meter #(
  parameter int CNT_W    = 16,
  parameter int NUM_DEC  = 3,
  parameter int WIN_LOG2 = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_wr,
  input  logic [scm_pkg::SEL_W-1:0] sel_data,
  input  logic [NUM_DEC-1:0]        sync_evt,
  input  logic                      ref_tick,
  output logic [CNT_W-1:0]          result
);
  import scm_pkg::*;

  logic       start, abort, busy, last_tick, cnt_en;
  dec_sel_t   sel_q;
  logic [CNT_W-1:0] count_next;

  assign start  = sel_wr && (sel_data != SEL_OFF);
  assign abort  = sel_wr && (sel_data == SEL_OFF);
  // the write cycle itself counts nothing
  assign cnt_en = busy && !sel_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (start) sel_q <= sel_data;
  end

  scm_window_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .abort     (abort),
    .tick      (ref_tick),
    .busy      (busy),
    .last_tick (last_tick)
  );

  scm_event_counter #(.CNT_W(CNT_W), .NUM_DEC(NUM_DEC), .SEL_W(SEL_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .enable     (cnt_en),
    .sel        (sel_q),
    .evt        (sync_evt),
    .count_next (count_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              result <= '0;
    else if (sel_wr)         result <= '0;
    else if (last_tick)      result <= count_next;
  end

  a_r3_zero_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> result == '0);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && result == '0));

  a_r8_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && result == '0));

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sel_wr) |=> $stable(result));

  a_r9_capture_final: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> result == $past(count_next));

endmodule

// File: tb/sync_clock_meter_test.sv
module sync_clock_meter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_wr = 1'b0;
  logic [1:0]  sel_data = 2'd0;
  logic [2:0]  sync_evt = 3'd0;
  logic        ref_tick = 1'b0;
  logic [15:0] result;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // behavioural model
  bit m_busy = 0;
  int m_sel = 0, m_win = 0, m_cnt = 0, m_res = 0;

  always #2.5 clk = ~clk;

  sync_clock_meter uut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_data(sel_data),
    .sync_evt(sync_evt), .ref_tick(ref_tick), .result(result)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: result=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_win = 0; m_cnt = 0; m_res = 0; m_sel = 0;
    end else if (sel_wr) begin
      m_res = 0;
      if (sel_data != 2'd3) begin
        m_busy = 1; m_sel = sel_data; m_win = 0; m_cnt = 0;
      end else m_busy = 0;
    end else if (m_busy) begin
      if (sync_evt[m_sel] && m_cnt < 65535) m_cnt++;
      if (ref_tick) begin
        m_win++;
        if (m_win == 512) begin m_res = m_cnt; m_busy = 0; end
      end
    end
    #1;
    if (rst_n) check("R3 model compare", int'(result), m_res);
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: result=%0d expected=done", result);
      summary();
    end
  end

  task automatic one(input logic w, input logic [1:0] d, input logic [2:0] e, input logic t);
    sel_wr = w; sel_data = d; sync_evt = e; ref_tick = t;
    @(negedge clk);
    sel_wr = 1'b0; sync_evt = 3'd0; ref_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(result), 0);

    // decoder 1, tick every cycle, dec1 strobes on even cycles, others always
    one(1'b1, 2'd1, 3'b000, 1'b0);
    for (int k = 1; k <= 512; k++) begin
      one(1'b0, 2'd0, {1'b1, (k % 2 == 0), 1'b1}, 1'b1);
      if (k == 300) check("R3 reads zero mid-window", int'(result), 0);
    end
    check("R5 R9 decoder1 count", int'(result), 256);
    for (int k = 0; k < 40; k++) one(1'b0, 2'd0, 3'b111, 1'b1);
    check("R4 result held after window", int'(result), 256);

    // restart: begin on dec0, switch to dec2 mid-window
    one(1'b1, 2'd0, 3'b000, 1'b0);
    for (int k = 0; k < 100; k++) one(1'b0, 2'd0, 3'b111, 1'b1);
    one(1'b1, 2'd2, 3'b000, 1'b0);
    check("R6 zero after restart", int'(result), 0);
    for (int k = 1; k <= 1024; k++) one(1'b0, 2'd0, 3'b100, (k % 2 == 0));
    check("R6 R2 restart decoder2 count", int'(result), 1024);

    // abort
    one(1'b1, 2'd0, 3'b000, 1'b0);
    for (int k = 0; k < 50; k++) one(1'b0, 2'd0, 3'b001, 1'b1);
    one(1'b1, 2'd3, 3'b000, 1'b0);
    for (int k = 0; k < 600; k++) one(1'b0, 2'd0, 3'b111, 1'b1);
    check("R8 aborted stays zero", int'(result), 0);

    // strobe in write cycle ignored, strobe on closing tick counted
    one(1'b1, 2'd1, 3'b111, 1'b0);
    for (int k = 1; k <= 512; k++) one(1'b0, 2'd0, (k == 512) ? 3'b010 : 3'b000, 1'b1);
    check("R10 R9 boundary strobes", int'(result), 1);

    // disable when idle clears the held result
    one(1'b1, 2'd3, 3'b000, 1'b0);
    check("R8 disable clears held result", int'(result), 0);

    // saturation: strobe every cycle, tick every 130 cycles
    one(1'b1, 2'd0, 3'b000, 1'b0);
    for (int k = 1; k <= 66560; k++) one(1'b0, 2'd0, 3'b001, (k % 130 == 0));
    check("R7 saturated count", int'(result), 65535);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule